// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This peripheral sits behind a simple register port and performs 16-bit by 16-bit multiplications. Software loads two operand registers. Once both have been written, in either order, the unit runs one operation on its own. The operation is one of four kinds:

- plain multiply
- multiply and negate
- multiply and add to a 48-bit accumulator
- multiply and subtract from that accumulator

Three control inputs choose the behaviour. The operation kind comes from a 2-bit selector. A single bit picks two's-complement or unsigned operands. A further bit controls how the result snapshot is filled.

The accumulator is 48 bits wide and is read and written as three 16-bit words. The unit also keeps a read-only snapshot of result bits 31:16. Software can fetch this snapshot later, even after it has rewritten accumulator words by hand. Reads are registered: the data for an address presented in one cycle appears on the read port after the next rising edge.

Top module: `mac_unit`

## Requirements
- R1: After reset, every addressable register reads 0000h. The addresses are 0 for operand A, 1 for operand B, 2 for accumulator bits 15:0, 3 for bits 31:16, 4 for bits 47:32 and 5 for the snapshot. Any other address reads 0000h.
- R2: Writing only one operand register, once or several times, starts no operation and leaves the accumulator unchanged.
- R3: An operation starts on the rising edge after the edge that captures the second operand write, in either order, and its result is written to the accumulator on that edge. The registered read port returns the new value one edge later.
- R4: With op_sel = 2'b00, the accumulator is overwritten with the 32-bit product, extended to 48 bits.
- R5: With op_sel = 2'b01, the accumulator is overwritten with the two's-complement negation, modulo 2^48, of the extended product.
- R6: With op_sel = 2'b10, the extended product is added to the accumulator modulo 2^48.
- R7: With op_sel = 2'b11, the extended product is subtracted from the accumulator modulo 2^48.
- R8: When sgn_sel is 1, operands and product are two's complement and the product is sign-extended, so bit 47 is the sign. When sgn_sel is 0, everything is unsigned and the product is zero-extended.
- R9: Each accumulator word can be written and read back on its own at its address.
- R10: If keep_sum is 1, or the operation was 2'b00 or 2'b01, the snapshot (address 5) equals accumulator bits 31:16 right after the operation.
- R11: The snapshot is read-only. Writes to address 5, and direct writes to accumulator words, leave it unchanged until the next operation.
- R12: When a direct accumulator-word write lands on the same edge as an operation result, the operation result is kept.
- R13: Once an operation has started, both operand-loaded indications are cleared. A further single operand write does not start another operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| op_sel | input | 2 | Operation kind: 00 multiply, 01 negate, 10 accumulate, 11 subtract |
| sgn_sel | input | 1 | 1 = signed operands, 0 = unsigned |
| keep_sum | input | 1 | 1 = snapshot is taken from the updated accumulator for every kind |

## Verification
The second operand write is captured on edge N. The accumulator changes on edge N+1, and the read port shows that change on edge N+2. One directed test samples the read port after N, after N+1 and after N+2, and expects the old value, the old value and the new value in turn. The table-driven tests wait two edges after the second write before reading, so every read they make sees the settled result. The snapshot is compared only where R10 promises a value. A collision test places a direct accumulator write exactly on edge N+1.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_NEG = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } mac_op_e;

  localparam int ADR_OPA  = 0;
  localparam int ADR_OPB  = 1;
  localparam int ACC_BASE = 2;
endpackage

// File: rtl/mac_operands.sv
module mac_operands
  import mac_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      opa,
  output logic [W-1:0]      opb,
  output logic              start
);
  logic a_seen, b_seen;
  logic wa, wb;

  assign wa = wr_en && (wr_addr == ADDR_W'(ADR_OPA));
  assign wb = wr_en && (wr_addr == ADDR_W'(ADR_OPB));

  always_ff @(posedge clk) begin
    if (rst) begin
      opa    <= '0;
      opb    <= '0;
      a_seen <= 1'b0;
      b_seen <= 1'b0;
      start  <= 1'b0;
    end else begin
      start <= 1'b0;
      if (wa) opa <= wr_data;
      if (wb) opb <= wr_data;
      if ((wa && b_seen) || (wb && a_seen)) begin
        start  <= 1'b1;
        a_seen <= 1'b0;
        b_seen <= 1'b0;
      end else begin
        if (wa) a_seen <= 1'b1;
        if (wb) b_seen <= 1'b1;
      end
    end
  end

  // R13
  flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (!a_seen && !b_seen));

  // R2
  start_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(wr_en));
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 48
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic          sgn,
  input  logic [1:0]    op,
  input  logic          keep_sum,
  input  logic [AW-1:0] acc,
  output logic [AW-1:0] acc_next,
  output logic [W-1:0]  snap_next
);
  localparam int PF = 2 * W + 2;

  logic signed [W:0]    xa, xb;
  logic signed [PF-1:0] prod;
  logic [AW-1:0]        ext;

  assign xa   = {sgn & opa[W-1], opa};
  assign xb   = {sgn & opb[W-1], opb};
  assign prod = xa * xb;
  assign ext  = {{(AW-PF){prod[PF-1]}}, prod};

  always_comb begin
    unique case (mac_op_e'(op))
      OP_MUL:  acc_next = ext;
      OP_NEG:  acc_next = '0 - ext;
      OP_ADD:  acc_next = acc + ext;
      default: acc_next = acc - ext;
    endcase
  end

  always_comb begin
    if (keep_sum || !op[1]) snap_next = acc_next[2*W-1:W];
    else                    snap_next = ext[2*W-1:W];
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int W      = 16,
  parameter int AW     = 48,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              start,
  input  logic [AW-1:0]     acc_next,
  input  logic [W-1:0]      snap_next,
  output logic [AW-1:0]     acc,
  output logic [W-1:0]      snap
);
  localparam int NW = AW / W;

  logic [NW-1:0][W-1:0] words;

  assign acc = words;

  always_ff @(posedge clk) begin
    if (rst) begin
      words <= '0;
      snap  <= '0;
    end else if (start) begin
      words <= acc_next;
      snap  <= snap_next;
    end else if (wr_en) begin
      for (int i = 0; i < NW; i++) begin
        if (wr_addr == ADDR_W'(ACC_BASE + i)) words[i] <= wr_data;
      end
    end
  end

  // R12
  result_wins_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (acc == $past(acc_next)));

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(snap));

  // R9
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !wr_en) |=> $stable(acc));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int W      = 16,
  parameter int AW     = 48,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [1:0]        op_sel,
  input  logic              sgn_sel,
  input  logic              keep_sum
);
  localparam int NW       = AW / W;
  localparam int ADR_SNAP = ACC_BASE + NW;

  logic [W-1:0]  opa, opb, snap_next, snap;
  logic [AW-1:0] acc, acc_next;
  logic          start;

  mac_operands #(.W(W), .ADDR_W(ADDR_W)) u_ops (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .opa(opa), .opb(opb), .start(start)
  );

  mac_datapath #(.W(W), .AW(AW)) u_dp (
    .opa(opa), .opb(opb), .sgn(sgn_sel), .op(op_sel),
    .keep_sum(keep_sum), .acc(acc), .acc_next(acc_next),
    .snap_next(snap_next)
  );

  mac_accum #(.W(W), .AW(AW), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .acc_next(acc_next),
    .snap_next(snap_next), .acc(acc), .snap(snap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_addr == ADDR_W'(ADR_OPA)) rd_data <= opa;
      if (rd_addr == ADDR_W'(ADR_OPB)) rd_data <= opb;
      if (rd_addr == ADDR_W'(ADR_SNAP)) rd_data <= snap;
      for (int i = 0; i < NW; i++) begin
        if (rd_addr == ADDR_W'(ACC_BASE + i)) rd_data <= acc[i*W +: W];
      end
    end
  end

  // R10
  snap_match_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (!($past(keep_sum) || !$past(op_sel[1])) || (snap == acc[2*W-1:W])));
endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  op_sel = '0;
  logic        sgn_sel = 1'b0;
  logic        keep_sum = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .op_sel(op_sel), .sgn_sel(sgn_sel),
    .keep_sum(keep_sum)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        sgn;
    logic        keep;
    logic        bfirst;
    logic [15:0] a;
    logic [15:0] b;
    logic [47:0] init;
    logic [47:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b1, 1'b0, 16'h0003, 16'h0005, 48'h0,            48'h00000000000F},
    '{2'b00, 1'b1, 1'b1, 1'b1, 16'hFFFE, 16'h0003, 48'h123456789ABC, 48'hFFFFFFFFFFFA},
    '{2'b00, 1'b0, 1'b1, 1'b0, 16'hFFFE, 16'h0003, 48'h0,            48'h00000002FFFA},
    '{2'b01, 1'b1, 1'b1, 1'b1, 16'h0002, 16'h0003, 48'h0,            48'hFFFFFFFFFFFA},
    '{2'b10, 1'b0, 1'b1, 1'b0, 16'h0100, 16'h0100, 48'h000000010000, 48'h000000020000},
    '{2'b11, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0001, 48'h0,            48'h000000000001},
    '{2'b10, 1'b0, 1'b1, 1'b0, 16'h0001, 16'h0001, 48'hFFFFFFFFFFFF, 48'h000000000000},
    '{2'b11, 1'b0, 1'b1, 1'b1, 16'h0001, 16'h0001, 48'h0,            48'hFFFFFFFFFFFF},
    '{2'b01, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 48'h0,            48'hFFFF0001FFFF},
    '{2'b00, 1'b1, 1'b1, 1'b1, 16'h8000, 16'h8000, 48'h0,            48'h000040000000},
    '{2'b10, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 48'h00007FFFFFFF, 48'h000080000000},
    '{2'b11, 1'b1, 1'b0, 1'b0, 16'h0002, 16'h0003, 48'h000000000010, 48'h00000000000A}
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rd_acc(output logic [47:0] v);
    logic [15:0] w0, w1, w2;
    rd(3'd2, w0); rd(3'd3, w1); rd(3'd4, w2);
    v = {w2, w1, w0};
  endtask

  task automatic set_acc(input logic [47:0] v);
    wr(3'd2, v[15:0]); wr(3'd3, v[31:16]); wr(3'd4, v[47:32]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [47:0] v, snap_v;
    string req;

    repeat (3) @(posedge clk); #1;
    rst = 1'b0;

    // R1: every address reads zero after reset, unmapped too
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      chk("R1 reset read", {32'h0, d}, 48'h0);
    end

    // R9: individual word write and read back
    set_acc(48'hA5A5_3C3C_1234);
    rd(3'd2, d); chk("R9 word0", {32'h0, d}, 48'h1234);
    rd(3'd3, d); chk("R9 word1", {32'h0, d}, 48'h3C3C);
    rd(3'd4, d); chk("R9 word2", {32'h0, d}, 48'hA5A5);

    // Table walk: R4 R5 R6 R7 by op_sel, R10 snapshot where guaranteed
    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        2'b00: req = "R4 multiply";
        2'b01: req = "R5 negate";
        2'b10: req = "R6 accumulate";
        default: req = "R7 subtract";
      endcase
      set_acc(VECS[k].init);
      op_sel = VECS[k].op; sgn_sel = VECS[k].sgn; keep_sum = VECS[k].keep;
      if (VECS[k].bfirst) begin
        wr(3'd1, VECS[k].b); wr(3'd0, VECS[k].a);
      end else begin
        wr(3'd0, VECS[k].a); wr(3'd1, VECS[k].b);
      end
      idle(2);
      rd_acc(v);
      chk(req, v, VECS[k].exp);
      if (VECS[k].keep || !VECS[k].op[1]) begin
        rd(3'd5, d);
        chk("R10 snapshot", {32'h0, d}, {32'h0, VECS[k].exp[31:16]});
      end
    end

    // R8: same operands, signed versus unsigned multiply
    op_sel = 2'b00; keep_sum = 1'b1;
    sgn_sel = 1'b0; wr(3'd0, 16'hFFFF); wr(3'd1, 16'h0002); idle(2);
    rd_acc(v); chk("R8 unsigned zero-extend", v, 48'h00000001FFFE);
    sgn_sel = 1'b1; wr(3'd0, 16'hFFFF); wr(3'd1, 16'h0002); idle(2);
    rd_acc(v); chk("R8 signed sign-extend", v, 48'hFFFFFFFFFFFE);

    // R11: snapshot survives writes to its address and to accumulator words
    rd(3'd5, d); snap_v = {32'h0, d};
    chk("R11 snapshot before writes", snap_v, 48'h00FFFF);
    wr(3'd5, 16'hBEEF); wr(3'd3, 16'h7777); idle(1);
    rd(3'd5, d); chk("R11 snapshot held", {32'h0, d}, snap_v);
    rd(3'd3, d); chk("R9 word1 rewritten", {32'h0, d}, 48'h7777);

    // R2 and R13: single operand writes do not start an operation
    set_acc(48'h0000_0000_4444);
    op_sel = 2'b00; sgn_sel = 1'b0;
    wr(3'd0, 16'h0009); wr(3'd0, 16'h000B); idle(3);
    rd_acc(v); chk("R2 one operand only", v, 48'h000000004444);
    wr(3'd1, 16'h0002); idle(2);
    rd_acc(v); chk("R2 latest A used", v, 48'h000000000016);
    wr(3'd1, 16'h0005); idle(3);
    rd_acc(v); chk("R13 flags cleared after start", v, 48'h000000000016);
    wr(3'd0, 16'h0003); idle(2);
    rd_acc(v); chk("R13 new pair starts", v, 48'h00000000000F);

    // R3: exact cycle of the result on the read port
    set_acc(48'h0000_0000_5555);
    wr(3'd0, 16'h0007);
    @(negedge clk); rd_addr = 3'd2;
    wr(3'd1, 16'h0009);
    @(negedge clk); chk("R3 after capture edge", {32'h0, rd_data}, 48'h5555);
    @(negedge clk); chk("R3 after result edge", {32'h0, rd_data}, 48'h5555);
    @(negedge clk); chk("R3 one edge later", {32'h0, rd_data}, 48'h003F);

    // R12: direct word write on the result edge loses
    set_acc(48'h0);
    wr(3'd0, 16'h0002); wr(3'd1, 16'h0003); wr(3'd2, 16'h1234); idle(1);
    rd_acc(v); chk("R12 result wins", v, 48'h000000000006);

    // R1: reset after activity clears everything
    @(negedge clk); rst = 1'b1;
    idle(2); #1; rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d);
      chk("R1 second reset", {32'h0, d}, 48'h0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule